// File: doc/BRIEF.md
# Bridge Delayed-Transaction Discard Timer

A bus-to-bus bridge queues a delayed transaction when a master's request cannot be finished at once. The master is then expected to retry. If the master never returns, the queued entry would hold bridge resources forever. This block keeps one watchdog per side of the bridge, primary and secondary. Each one is armed when a delayed transaction is queued on its side. It is disarmed when the originating master retries and completes. If the timer runs out first, it emits a one-cycle discard pulse so the queue logic can drop the entry.

The timeout of each side is chosen at run time from a bridge control word. A side's select bit at 1 picks the short window of 2^10 cycles, and at 0 picks the long window of 2^15 cycles. Any expiry sets a sticky timeout flag in the same control word, and software clears that flag by writing a one to it. If escalation is enabled, every expiry edge also produces a single-cycle system-error request toward the primary bus.

Top module: `xfer_discard_timer`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it rises, both discard outputs, serr_req_o and timeout_sticky_o are 0 and bctl_q_o reads 0. A timer that was counting when reset was applied produces no discard afterwards.
- R2: With the side's select bit at 1, the discard output of that side rises exactly 1024 clock edges after the edge that sampled its start strobe.
- R3: With the side's select bit at 0, the discard output rises exactly 32768 clock edges after the start edge. The select value sampled at the start edge sets the length.
- R4: Bit 8 of the control word selects the primary length and bit 9 selects the secondary length. A strobe on one side never causes a discard on the other side, and both sides may expire on the same edge.
- R5: A complete strobe disarms its side without a discard. This holds even when the complete is sampled on the very edge on which expiry would occur.
- R6: A start strobe while armed reloads the count from that edge. A start on the expiry edge wins, so no discard occurs there and the full window begins again.
- R7: A discard is high for exactly one cycle and leaves the side disarmed, so there is no further discard without a new start.
- R8: Any expiry sets bit 10 of bctl_q_o (timeout_sticky_o), and the bit stays set until cleared.
- R9: Writing bctl_wdata_i with bit 10 at 1 clears the flag, and writing 0 there leaves it unchanged. When an expiry and a clearing write share an edge, the flag ends set.
- R10: With bit 11 set, serr_req_o is high for one cycle on each edge on which at least one side expires. Two sides expiring together give one pulse. With bit 11 clear, it stays 0.
- R11: A write loads bits 8, 9 and 11 of bctl_q_o from bctl_wdata_i. Every bit other than 8 to 11 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prim_start_i | input | 1 | Primary-side delayed transaction queued |
| prim_done_i | input | 1 | Primary-side transaction completed by retry |
| sec_start_i | input | 1 | Secondary-side delayed transaction queued |
| sec_done_i | input | 1 | Secondary-side transaction completed by retry |
| bctl_wr_i | input | 1 | Control word write strobe |
| bctl_wdata_i | input | 16 | Control word write data |
| bctl_q_o | output | 16 | Current control word |
| prim_discard_o | output | 1 | One-cycle primary discard pulse |
| sec_discard_o | output | 1 | One-cycle secondary discard pulse |
| timeout_sticky_o | output | 1 | Sticky timeout flag (bit 10) |
| serr_req_o | output | 1 | One-cycle system-error request |

## Verification
The hardest situations to reach are the collisions on the single edge where a count hits its end. On that edge a complete, a restart or a clearing write meets the expiry, and the priority order alone decides the outcome. The stimulus reaches each collision by counting edges from the start strobe with the known short length, then placing the competing strobe exactly on edge 1024, and also one edge before and one edge after it. Simultaneous expiry of both sides is produced by starting them on the same edge with equal lengths, which shows that the system-error request merges the two expiries into a single pulse.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CTRL_W      = 16;
  localparam int NSIDE       = 2;
  localparam int SEL_PRI_BIT = 8;
  localparam int SEL_SEC_BIT = 9;
  localparam int STAT_BIT    = 10;
  localparam int SERR_EN_BIT = 11;

  // Value loaded at start: window length minus one, the window being a power of two.
  function automatic int unsigned window_last(input logic short_sel,
                                              input int unsigned short_log2,
                                              input int unsigned long_log2);
    int unsigned lg;
    lg = short_sel ? short_log2 : long_log2;
    return (32'd1 << lg) - 32'd1;
  endfunction
endpackage

// File: rtl/dtmr_side.sv
module dtmr_side #(
  parameter int unsigned SHORT_LOG2 = 10,
  parameter int unsigned LONG_LOG2  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic short_sel_i,
  output logic fire_o,
  output logic discard_o
);
  import dtmr_pkg::*;
  localparam int CW = LONG_LOG2;

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          discard_q;
  logic          at_end;

  assign at_end = (cnt_q == '0);
  // Expiry event: terminal count reached with no competing strobe this edge.
  assign fire_o = armed_q && at_end && !start_i && !done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      discard_q <= fire_o;
      if (start_i) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(window_last(short_sel_i, SHORT_LOG2, LONG_LOG2));
      end else if (done_i || fire_o) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign discard_o = discard_q;

  AST_DISCARD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_q |=> !discard_q);  // R7
  AST_DISCARD_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    discard_q |-> !armed_q);  // R7
  AST_DONE_NO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> !discard_q);  // R5
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (armed_q && !discard_q));  // R6
endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [dtmr_pkg::CTRL_W-1:0]    wdata_i,
  input  logic [dtmr_pkg::NSIDE-1:0]     fire_i,
  output logic [dtmr_pkg::NSIDE-1:0]     short_sel_o,
  output logic                           stat_o,
  output logic                           serr_o,
  output logic [dtmr_pkg::CTRL_W-1:0]    ctrl_q_o
);
  import dtmr_pkg::*;

  logic       sel_pri_q, sel_sec_q, serr_en_q, stat_q, serr_q;
  logic       any_fire;
  logic       clr_req;

  assign any_fire = |fire_i;
  assign clr_req  = wr_i && wdata_i[STAT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_pri_q <= 1'b0;
      sel_sec_q <= 1'b0;
      serr_en_q <= 1'b0;
      stat_q    <= 1'b0;
      serr_q    <= 1'b0;
    end else begin
      if (wr_i) begin
        sel_pri_q <= wdata_i[SEL_PRI_BIT];
        sel_sec_q <= wdata_i[SEL_SEC_BIT];
        serr_en_q <= wdata_i[SERR_EN_BIT];
      end
      // Setting has priority over a simultaneous write-one-to-clear.
      if (any_fire)     stat_q <= 1'b1;
      else if (clr_req) stat_q <= 1'b0;
      serr_q <= any_fire && serr_en_q;
    end
  end

  always_comb begin
    ctrl_q_o              = '0;
    ctrl_q_o[SEL_PRI_BIT] = sel_pri_q;
    ctrl_q_o[SEL_SEC_BIT] = sel_sec_q;
    ctrl_q_o[STAT_BIT]    = stat_q;
    ctrl_q_o[SERR_EN_BIT] = serr_en_q;
  end

  assign short_sel_o = {sel_sec_q, sel_pri_q};
  assign stat_o      = stat_q;
  assign serr_o      = serr_q;

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_req) |=> stat_q);  // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire |=> stat_q);  // R9
  AST_SERR_IMPLIES_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    serr_q |-> stat_q);  // R10
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!serr_en_q && !wr_i) |=> !serr_q);  // R10
endmodule

// File: rtl/xfer_discard_timer.sv
module xfer_discard_timer #(
  parameter int unsigned SHORT_LOG2 = 10,
  parameter int unsigned LONG_LOG2  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prim_start_i,
  input  logic        prim_done_i,
  input  logic        sec_start_i,
  input  logic        sec_done_i,
  input  logic        bctl_wr_i,
  input  logic [15:0] bctl_wdata_i,
  output logic [15:0] bctl_q_o,
  output logic        prim_discard_o,
  output logic        sec_discard_o,
  output logic        timeout_sticky_o,
  output logic        serr_req_o
);
  import dtmr_pkg::*;

  logic [NSIDE-1:0] start_v, done_v, fire_v, discard_v, short_sel_v;

  assign start_v = {sec_start_i, prim_start_i};
  assign done_v  = {sec_done_i, prim_done_i};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dtmr_side #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_v[g]),
      .done_i     (done_v[g]),
      .short_sel_i(short_sel_v[g]),
      .fire_o     (fire_v[g]),
      .discard_o  (discard_v[g])
    );
  end

  dtmr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (bctl_wr_i),
    .wdata_i    (bctl_wdata_i),
    .fire_i     (fire_v),
    .short_sel_o(short_sel_v),
    .stat_o     (timeout_sticky_o),
    .serr_o     (serr_req_o),
    .ctrl_q_o   (bctl_q_o)
  );

  assign prim_discard_o = discard_v[0];
  assign sec_discard_o  = discard_v[1];

  AST_DISCARD_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_discard_o || sec_discard_o) |-> timeout_sticky_o);  // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bctl_q_o[7:0] == 8'h00) && (bctl_q_o[15:12] == 4'h0));  // R11
endmodule

// File: tb/xfer_discard_timer_test.sv
`timescale 1ns/1ps
module xfer_discard_timer_test;
  localparam int NS = 1024;
  localparam int NL = 32768;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prim_start = 0, prim_done = 0, sec_start = 0, sec_done = 0;
  logic bctl_wr = 0;
  logic [15:0] bctl_wdata = '0;
  logic [15:0] bctl_q;
  logic prim_discard, sec_discard, sticky, serr;

  always #2.5 clk = ~clk;

  xfer_discard_timer uut (
    .clk(clk), .rst_n(rst_n),
    .prim_start_i(prim_start), .prim_done_i(prim_done),
    .sec_start_i(sec_start), .sec_done_i(sec_done),
    .bctl_wr_i(bctl_wr), .bctl_wdata_i(bctl_wdata), .bctl_q_o(bctl_q),
    .prim_discard_o(prim_discard), .sec_discard_o(sec_discard),
    .timeout_sticky_o(sticky), .serr_req_o(serr)
  );

  int checks = 0, fails = 0;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    bctl_wr = 1; bctl_wdata = v; tick(); bctl_wr = 0; bctl_wdata = '0;
  endtask

  // Kinds: 0 nothing, 1 complete, 2 restart, 3 clearing write; strobe applied on edge d+1.
  typedef struct packed {
    logic        side;
    logic [1:0]  kind;
    logic [15:0] d;
    logic        serr_en;
    logic [15:0] exp_edge;
    logic        exp_stat;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 2'd0, 16'd0,      1'b1, 16'(NS),      1'b1},
    '{1'b1, 2'd0, 16'd0,      1'b0, 16'(NS),      1'b1},
    '{1'b0, 2'd1, 16'd0,      1'b1, 16'd0,        1'b0},
    '{1'b1, 2'd1, 16'(NS-2),  1'b1, 16'd0,        1'b0},
    '{1'b0, 2'd1, 16'(NS-1),  1'b1, 16'd0,        1'b0},
    '{1'b1, 2'd1, 16'(NS),    1'b1, 16'(NS),      1'b1},
    '{1'b0, 2'd2, 16'd10,     1'b0, 16'(NS+11),   1'b1},
    '{1'b1, 2'd2, 16'(NS-1),  1'b1, 16'(2*NS),    1'b1},
    '{1'b0, 2'd3, 16'(NS-1),  1'b0, 16'(NS),      1'b1},
    '{1'b1, 2'd3, 16'(NS),    1'b0, 16'(NS),      1'b0},
    '{1'b0, 2'd3, 16'd5,      1'b1, 16'(NS),      1'b1}
  };

  task automatic run_count(input int edges, output int p_first, output int p_cnt,
                           output int s_first, output int s_cnt, output int e_cnt);
    p_first = 0; p_cnt = 0; s_first = 0; s_cnt = 0; e_cnt = 0;
    for (int e = 1; e <= edges; e++) begin
      tick();
      if (prim_discard) begin p_cnt++; if (p_first == 0) p_first = e; end
      if (sec_discard)  begin s_cnt++; if (s_first == 0) s_first = e; end
      if (serr) e_cnt++;
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int pf, pc, sf, sc, ec;
    // R1 reset state
    tick(); tick();
    check("R1", bctl_q, 0, "ctrl word in reset");
    check("R1", {prim_discard, sec_discard, sticky, serr}, 0, "outputs in reset");
    rst_n = 1; tick();
    check("R1", bctl_q, 0, "ctrl word after reset");

    // R11 write all ones
    wr_ctrl(16'hFFFF);
    check("R11", bctl_q, 16'h0B00, "writable bits only");

    // Vector table
    foreach (VECS[i]) begin
      vec_t v;
      logic [15:0] cw;
      int first, nd, no, ns;
      v = VECS[i];
      cw = 16'h0300 | (16'(v.serr_en) << 11);
      wr_ctrl(cw | 16'h0400);
      if (v.side == 1'b0) prim_start = 1; else sec_start = 1;
      tick();
      prim_start = 0; sec_start = 0;
      first = 0; nd = 0; no = 0; ns = 0;
      for (int e = 1; e <= 2*NS + 20; e++) begin
        if (v.kind != 2'd0 && e == int'(v.d) + 1) begin
          case (v.kind)
            2'd1: if (v.side == 1'b0) prim_done = 1; else sec_done = 1;
            2'd2: if (v.side == 1'b0) prim_start = 1; else sec_start = 1;
            default: begin bctl_wr = 1; bctl_wdata = cw | 16'h0400; end
          endcase
        end
        tick();
        prim_done = 0; sec_done = 0; prim_start = 0; sec_start = 0;
        bctl_wr = 0; bctl_wdata = '0;
        if ((v.side == 1'b0) ? prim_discard : sec_discard) begin
          nd++; if (first == 0) first = e;
        end
        if ((v.side == 1'b0) ? sec_discard : prim_discard) no++;
        if (serr) ns++;
      end
      check(v.kind == 2'd1 ? "R5" : (v.kind == 2'd2 ? "R6" : "R2"), first, int'(v.exp_edge), "discard edge");
      check("R7", nd, (v.exp_edge != 0) ? 1 : 0, "discard pulse count");
      check("R4", no, 0, "other side discards");
      check("R10", ns, (v.serr_en && v.exp_edge != 0) ? 1 : 0, "serr pulses");
      check(v.kind == 2'd3 ? "R9" : "R8", int'(sticky), int'(v.exp_stat), "sticky flag");
    end

    // R8/R9 sticky and write-zero behaviour
    wr_ctrl(16'h0700);
    prim_start = 1; tick(); prim_start = 0;
    run_count(NS + 2, pf, pc, sf, sc, ec);
    check("R8", int'(sticky), 1, "flag set after expiry");
    check("R10", ec, 0, "no serr when disabled");
    wr_ctrl(16'h0300);
    for (int k = 0; k < 50; k++) tick();
    check("R9", int'(sticky), 1, "write zero keeps flag");
    wr_ctrl(16'h0700);
    check("R9", int'(sticky), 0, "write one clears flag");

    // R10 both sides expire together: one serr pulse
    wr_ctrl(16'h0F00);
    prim_start = 1; sec_start = 1; tick(); prim_start = 0; sec_start = 0;
    run_count(2*NS, pf, pc, sf, sc, ec);
    check("R4", pf, NS, "primary edge, joint expiry");
    check("R4", sf, NS, "secondary edge, joint expiry");
    check("R10", ec, 1, "merged serr pulse");

    // R3 long window on secondary, short on primary
    wr_ctrl(16'h0500);
    check("R11", bctl_q, 16'h0100, "primary short only");
    prim_start = 1; sec_start = 1; tick(); prim_start = 0; sec_start = 0;
    run_count(NL + 8, pf, pc, sf, sc, ec);
    check("R4", pf, NS, "primary short with secondary long");
    check("R3", sf, NL, "secondary long window");
    // R3 long window on primary
    wr_ctrl(16'h0600);
    prim_start = 1; tick(); prim_start = 0;
    run_count(NL + 8, pf, pc, sf, sc, ec);
    check("R3", pf, NL, "primary long window");
    check("R4", sc, 0, "secondary idle");

    // R1 reset during count
    wr_ctrl(16'h0B00);
    prim_start = 1; tick(); prim_start = 0;
    for (int k = 0; k < 100; k++) tick();
    rst_n = 0; tick();
    check("R1", {prim_discard, sec_discard, sticky, serr}, 0, "outputs under reset");
    tick(); rst_n = 1;
    run_count(2*NS, pf, pc, sf, sc, ec);
    check("R1", pc + sc + ec, 0, "no activity after reset");
    check("R1", bctl_q, 0, "ctrl word cleared by reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule